// File: doc/BRIEF.md
# Three-channel watchdog timer with bark interrupt

This peripheral holds three watchdog channels behind a small 32-bit register bus. Each channel owns a 32-bit up-counter that advances on a shared reference tick, a bite threshold and a control word. Software services a channel by writing zero to its counter. When the channel's reset enable is set and the counter is at or past the bite threshold (unsigned compare), the channel latches a reset request that stays high until the block itself is reset.

Channel 0 drives a recovery-class reset and also has a lower bark threshold that raises a level interrupt, cleared by writing one to its status bit. Channels 1 and 2 share the normal system reset output. Loading threshold zero, counter zero and reset enable gives software a way to force an immediate restart.

Top module: `tri_wdt`

## Requirements
- R1: After the active-low reset every mapped register reads 0 and the three outputs are low.
- R2: Byte map: channel n (n = 0, 1, 2) has its base at 0x10*n. The counter is at base+0x0, the bite threshold at base+0x4 and control at base+0xC. The bark threshold exists only at 0x08. Control bit 0 is the interrupt enable and bit 1 the interrupt status; both exist only in channel 0 and read 0 in channels 1 and 2. Control bit 2 is the reset enable. Reads are combinational in the same cycle.
- R3: Each counter adds one (modulo 2^32) at every clock edge where tick is high, whether or not anything is enabled. A counter write loads the value at that edge, and the tick of that edge is ignored.
- R4: When channel 0 has reset enable set and counter >= bite (unsigned), rst_recovery_o rises at the next edge and stays high until rst_n is asserted.
- R5: The same condition on channel 1 or channel 2 raises rst_system_o, which is sticky in the same way.
- R6: When channel 0 has interrupt enable set and counter >= bark, the status bit is set at the next edge; irq_o equals that status bit.
- R7: Writing channel 0 control with bit 1 set clears the status, except when the interrupt condition is true in that same cycle, in which case the status stays set. Writing 0 to bit 1 leaves the status unchanged.
- R8: With reset enable set, threshold 0 and counter written 0, the reset request is raised at the next edge.
- R9: Reads of unmapped or misaligned addresses, including 0x18 and 0x28, return 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Reference tick enable for the counters |
| wr_en | input | 1 | Register write strobe |
| addr | input | 6 | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr |
| rst_recovery_o | output | 1 | Sticky recovery-class reset request (channel 0) |
| rst_system_o | output | 1 | Sticky normal reset request (channels 1 and 2) |
| irq_o | output | 1 | Level bark interrupt of channel 0 |

## Verification
Two pairs of functions can land on the same edge. In the first, a write-one-to-clear of the bark status arrives while the counter is still at or above the bark threshold. The bench provokes this by clearing while the tick is running past the threshold, and the status must stay set. Clearing after servicing the counter must drop the status. In the second, a counter write meets an active tick. The bench reads the counter straight after the write and expects the written value, with no increment. A behavioural model is compared with every output on each clock.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int DATA_W  = 32;
  localparam int NUM_CH  = 3;
  localparam int CH_BITS = $clog2(NUM_CH);
  localparam int ADDR_W  = CH_BITS + 4;

  // word slot within a channel, from addr[3:2]
  localparam logic [1:0] SLOT_CNT  = 2'd0;
  localparam logic [1:0] SLOT_BITE = 2'd1;
  localparam logic [1:0] SLOT_BARK = 2'd2;
  localparam logic [1:0] SLOT_CTRL = 2'd3;

  // control word bit positions
  localparam int CB_IEN = 0;
  localparam int CB_IST = 1;
  localparam int CB_REN = 2;
endpackage

// File: rtl/wdt_decode.sv
module wdt_decode
  import wdt_pkg::*;
(
  input  logic [ADDR_W-1:0]  addr,
  input  logic               wr_en,
  output logic               hit,
  output logic [CH_BITS-1:0] ch_sel,
  output logic [1:0]         slot_sel,
  output logic [NUM_CH-1:0]  cnt_we,
  output logic [NUM_CH-1:0]  bite_we,
  output logic [NUM_CH-1:0]  bark_we,
  output logic [NUM_CH-1:0]  ctrl_we
);
  always_comb begin
    ch_sel   = addr[ADDR_W-1:4];
    slot_sel = addr[3:2];
    hit      = (addr[1:0] == 2'b00) && (int'(ch_sel) < NUM_CH);
    if (slot_sel == SLOT_BARK && ch_sel != '0) hit = 1'b0;
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_we
    logic sel_c;
    assign sel_c      = wr_en && hit && (int'(ch_sel) == c);
    assign cnt_we[c]  = sel_c && (slot_sel == SLOT_CNT);
    assign bite_we[c] = sel_c && (slot_sel == SLOT_BITE);
    assign bark_we[c] = sel_c && (slot_sel == SLOT_BARK);
    assign ctrl_we[c] = sel_c && (slot_sel == SLOT_CTRL);
  end
endmodule

// File: rtl/wdt_channel.sv
module wdt_channel
  import wdt_pkg::*;
#(
  parameter bit HAS_IRQ = 1'b0,
  parameter int W       = DATA_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [W-1:0] wdata,
  input  logic         cnt_we,
  input  logic         bite_we,
  input  logic         bark_we,
  input  logic         ctrl_we,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] bite_o,
  output logic [W-1:0] bark_o,
  output logic         ien_o,
  output logic         ist_o,
  output logic         ren_o,
  output logic         req_o
);
  logic [W-1:0] cnt_q, cnt_d, bite_q, bite_d;
  logic         ren_q, ren_d, req_q, req_d;

  always_comb begin
    cnt_d = cnt_q;
    if (cnt_we)    cnt_d = wdata;
    else if (tick) cnt_d = cnt_q + 1'b1;
    bite_d = bite_we ? wdata : bite_q;
    ren_d  = ctrl_we ? wdata[CB_REN] : ren_q;
    req_d  = req_q | (ren_q && (cnt_q >= bite_q));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      bite_q <= '0;
      ren_q  <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      bite_q <= bite_d;
      ren_q  <= ren_d;
      req_q  <= req_d;
    end
  end

  assign cnt_o  = cnt_q;
  assign bite_o = bite_q;
  assign ren_o  = ren_q;
  assign req_o  = req_q;

  if (HAS_IRQ) begin : g_irq
    logic [W-1:0] bark_q, bark_d;
    logic         ien_q, ien_d, ist_q, ist_d;
    logic         clr;

    always_comb begin
      clr    = ctrl_we && wdata[CB_IST];
      bark_d = bark_we ? wdata : bark_q;
      ien_d  = ctrl_we ? wdata[CB_IEN] : ien_q;
      ist_d  = (ist_q && !clr) || (ien_q && (cnt_q >= bark_q));
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bark_q <= '0;
        ien_q  <= 1'b0;
        ist_q  <= 1'b0;
      end else begin
        bark_q <= bark_d;
        ien_q  <= ien_d;
        ist_q  <= ist_d;
      end
    end

    assign bark_o = bark_q;
    assign ien_o  = ien_q;
    assign ist_o  = ist_q;
  end else begin : g_noirq
    logic unused_bark_we;
    assign unused_bark_we = bark_we;
    assign bark_o = '0;
    assign ien_o  = 1'b0;
    assign ist_o  = 1'b0;
  end
endmodule

// File: rtl/tri_wdt.sv
module tri_wdt
  import wdt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rst_recovery_o,
  output logic              rst_system_o,
  output logic              irq_o
);
  logic               hit;
  logic [CH_BITS-1:0] ch_sel;
  logic [1:0]         slot_sel;
  logic [NUM_CH-1:0]  cnt_we, bite_we, bark_we, ctrl_we;

  logic [DATA_W-1:0]  cnt_q  [NUM_CH];
  logic [DATA_W-1:0]  bite_q [NUM_CH];
  logic [DATA_W-1:0]  bark_q [NUM_CH];
  logic [NUM_CH-1:0]  ien_q, ist_q, ren_q, req_q;

  wdt_decode u_dec (
    .addr     (addr),
    .wr_en    (wr_en),
    .hit      (hit),
    .ch_sel   (ch_sel),
    .slot_sel (slot_sel),
    .cnt_we   (cnt_we),
    .bite_we  (bite_we),
    .bark_we  (bark_we),
    .ctrl_we  (ctrl_we)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    wdt_channel #(.HAS_IRQ(c == 0), .W(DATA_W)) u_ch (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .wdata   (wdata),
      .cnt_we  (cnt_we[c]),
      .bite_we (bite_we[c]),
      .bark_we (bark_we[c]),
      .ctrl_we (ctrl_we[c]),
      .cnt_o   (cnt_q[c]),
      .bite_o  (bite_q[c]),
      .bark_o  (bark_q[c]),
      .ien_o   (ien_q[c]),
      .ist_o   (ist_q[c]),
      .ren_o   (ren_q[c]),
      .req_o   (req_q[c])
    );
  end

  always_comb begin
    rdata = '0;
    if (hit) begin
      case (slot_sel)
        SLOT_CNT:  rdata = cnt_q[ch_sel];
        SLOT_BITE: rdata = bite_q[ch_sel];
        SLOT_BARK: rdata = bark_q[ch_sel];
        default: begin
          rdata[CB_IEN] = ien_q[ch_sel];
          rdata[CB_IST] = ist_q[ch_sel];
          rdata[CB_REN] = ren_q[ch_sel];
        end
      endcase
    end
  end

  assign rst_recovery_o = req_q[0];
  assign rst_system_o   = |req_q[NUM_CH-1:1];
  assign irq_o          = ist_q[0];
endmodule

// File: rtl/tri_wdt_chk.sv
module tri_wdt_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        tick,
  input logic        cnt_we0,
  input logic [31:0] cnt0,
  input logic        ien0,
  input logic        irq_o,
  input logic        rst_recovery_o,
  input logic        rst_system_o
);
  // R3
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cnt_we0) |=> (cnt0 == $past(cnt0) + 32'd1));

  // R4
  recovery_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_recovery_o |=> rst_recovery_o);

  // R5
  system_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_system_o |=> rst_system_o);

  // R6
  irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(ien0));
endmodule

bind tri_wdt tri_wdt_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .tick           (tick),
  .cnt_we0        (cnt_we[0]),
  .cnt0           (cnt_q[0]),
  .ien0           (ien_q[0]),
  .irq_o          (irq_o),
  .rst_recovery_o (rst_recovery_o),
  .rst_system_o   (rst_system_o)
);

// File: tb/tb_tri_wdt.sv
`timescale 1ns/1ps
module tb_tri_wdt;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rst_recovery_o, rst_system_o, irq_o;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit cmp_on = 1'b0;

  always #2.5 clk = ~clk;

  tri_wdt dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rst_recovery_o(rst_recovery_o),
    .rst_system_o(rst_system_o), .irq_o(irq_o)
  );

  // behavioural reference model
  logic [31:0] m_cnt [3];
  logic [31:0] m_bite [3];
  logic [31:0] m_bark;
  bit          m_ien, m_ist;
  bit          m_ren [3];
  bit          m_req [3];

  function automatic logic [31:0] m_read(input logic [5:0] a);
    case (a)
      6'h00: return m_cnt[0];
      6'h04: return m_bite[0];
      6'h08: return m_bark;
      6'h0C: return {29'd0, m_ren[0], m_ist, m_ien};
      6'h10: return m_cnt[1];
      6'h14: return m_bite[1];
      6'h1C: return {29'd0, m_ren[1], 2'b00};
      6'h20: return m_cnt[2];
      6'h24: return m_bite[2];
      6'h2C: return {29'd0, m_ren[2], 2'b00};
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 3; i++) begin
        m_cnt[i] = 0; m_bite[i] = 0; m_ren[i] = 0; m_req[i] = 0;
      end
      m_bark = 0; m_ien = 0; m_ist = 0;
    end else begin
      logic [31:0] nc [3];
      bit clr;
      for (int i = 0; i < 3; i++)
        if (m_ren[i] && m_cnt[i] >= m_bite[i]) m_req[i] = 1;
      clr = wr_en && addr == 6'h0C && wdata[1];
      m_ist = (m_ist && !clr) || (m_ien && m_cnt[0] >= m_bark);
      for (int i = 0; i < 3; i++) nc[i] = tick ? m_cnt[i] + 32'd1 : m_cnt[i];
      if (wr_en) begin
        case (addr)
          6'h00: nc[0] = wdata;
          6'h04: m_bite[0] = wdata;
          6'h08: m_bark = wdata;
          6'h0C: begin m_ien = wdata[0]; m_ren[0] = wdata[2]; end
          6'h10: nc[1] = wdata;
          6'h14: m_bite[1] = wdata;
          6'h1C: m_ren[1] = wdata[2];
          6'h20: nc[2] = wdata;
          6'h24: m_bite[2] = wdata;
          6'h2C: m_ren[2] = wdata[2];
          default: ;
        endcase
      end
      for (int i = 0; i < 3; i++) m_cnt[i] = nc[i];
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-clock comparison with the model, away from the active edge
  always @(negedge clk) begin
    if (rst_n && cmp_on) begin
      chk("R2 model rdata", rdata, m_read(addr));
      chk("R4 model rst_recovery_o", {31'd0, rst_recovery_o}, {31'd0, m_req[0]});
      chk("R5 model rst_system_o", {31'd0, rst_system_o}, {31'd0, m_req[1] | m_req[2]});
      chk("R6 model irq_o", {31'd0, irq_o}, {31'd0, m_ist});
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [5:0] a, input logic [31:0] exp);
    addr = a;
    @(negedge clk);
    chk(tag, rdata, exp);
    @(posedge clk); #1;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; wr_en = 1'b0; tick = 1'b0;
    cyc(2);
    rst_n = 1'b1;
  endtask

  initial begin
    do_reset();
    cmp_on = 1'b1;

    // R1: reset state
    for (int a = 0; a < 48; a += 4) rd("R1 reset read", a[5:0], 32'd0);
    chk("R1 outputs low", {29'd0, rst_recovery_o, rst_system_o, irq_o}, 32'd0);

    // R3: counting, write-vs-tick collision, wrap
    tick = 1'b1;
    wr(6'h20, 32'd100);
    rd("R3 write wins over tick", 6'h20, 32'd100);
    rd("R3 increment after write", 6'h20, 32'd101);
    wr(6'h20, 32'hFFFF_FFFF);
    rd("R3 load all ones", 6'h20, 32'hFFFF_FFFF);
    rd("R3 wrap to zero", 6'h20, 32'd0);
    tick = 1'b0;
    cyc(3);
    rd("R3 hold without tick", 6'h20, 32'd1);

    // R4: unsigned compare and stickiness on channel 0
    wr(6'h04, 32'h8000_0000);
    wr(6'h00, 32'h7FFF_FFFF);
    wr(6'h0C, 32'h4);
    cyc(2);
    chk("R4 below bite unsigned", {31'd0, rst_recovery_o}, 32'd0);
    wr(6'h00, 32'hFFFF_FFF0);
    cyc(1);
    chk("R4 at/above bite", {31'd0, rst_recovery_o}, 32'd1);
    chk("R4 system untouched", {31'd0, rst_system_o}, 32'd0);
    wr(6'h00, 32'd0);
    cyc(3);
    chk("R4 sticky after service", {31'd0, rst_recovery_o}, 32'd1);
    do_reset();
    chk("R4 cleared by reset", {31'd0, rst_recovery_o}, 32'd0);

    // R5: channel 1 timeout with running tick
    tick = 1'b1;
    wr(6'h14, 32'd20);
    wr(6'h1C, 32'h4);
    wr(6'h10, 32'd0);
    cyc(10);
    chk("R5 before timeout", {31'd0, rst_system_o}, 32'd0);
    cyc(15);
    chk("R5 after timeout", {31'd0, rst_system_o}, 32'd1);
    chk("R5 recovery untouched", {31'd0, rst_recovery_o}, 32'd0);

    // R8: immediate restart on channel 2
    do_reset();
    wr(6'h24, 32'hFFFF_FFFF);
    wr(6'h2C, 32'h4);
    cyc(2);
    chk("R8 idle threshold", {31'd0, rst_system_o}, 32'd0);
    wr(6'h24, 32'd0);
    wr(6'h20, 32'd0);
    cyc(1);
    chk("R8 immediate restart", {31'd0, rst_system_o}, 32'd1);

    // R6 / R7: bark interrupt and write-one-to-clear collision
    do_reset();
    tick = 1'b1;
    wr(6'h08, 32'd10);
    wr(6'h0C, 32'h1);
    wr(6'h00, 32'd0);
    cyc(5);
    chk("R6 below bark", {31'd0, irq_o}, 32'd0);
    cyc(10);
    chk("R6 bark raised", {31'd0, irq_o}, 32'd1);
    wr(6'h0C, 32'h3);
    chk("R7 set wins over clear", {31'd0, irq_o}, 32'd1);
    wr(6'h0C, 32'h1);
    chk("R7 zero write keeps status", {31'd0, irq_o}, 32'd1);
    tick = 1'b0;
    wr(6'h00, 32'd0);
    wr(6'h0C, 32'h3);
    chk("R7 clear after service", {31'd0, irq_o}, 32'd0);
    rd("R2 ctrl readback ch0", 6'h0C, 32'h1);
    wr(6'h0C, 32'h0);
    wr(6'h00, 32'd50);
    cyc(2);
    chk("R6 disabled no bark", {31'd0, irq_o}, 32'd0);

    // R9 / R2: unmapped and missing slots
    wr(6'h14, 32'h1234);
    wr(6'h18, 32'hDEAD_BEEF);
    wr(6'h28, 32'hDEAD_BEEF);
    wr(6'h30, 32'hDEAD_BEEF);
    wr(6'h15, 32'hDEAD_BEEF);
    rd("R9 threshold untouched", 6'h14, 32'h1234);
    rd("R9 ch1 bark slot", 6'h18, 32'd0);
    rd("R9 ch2 bark slot", 6'h28, 32'd0);
    rd("R9 unmapped 0x30", 6'h30, 32'd0);
    rd("R9 misaligned", 6'h15, 32'd0);
    rd("R9 ch0 counter untouched", 6'h00, 32'd50);
    wr(6'h1C, 32'h7);
    rd("R2 ch1 ctrl only reset enable", 6'h1C, 32'h4);

    cyc(3);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule